// File: doc/BRIEF.md
# Always-On Compare Timer

This block is a 32-bit up-counting timer meant for a chip's always-on power domain. Software programs it through a small register bus with single-cycle writes and registered reads. A tick enable drives the counter. That tick starts from one of two oscillator tick inputs or from the bus clock itself, and it then passes through two dividers in series. The first divider sits in the control register, can be bypassed, and divides by its field value plus one. The second divider has its own register and divides by its value, with zero treated as one.

When an increment brings the count equal to the programmed end value, the counter stops and a sticky match flag is set. The flag can be read at two addresses and is also driven out on `match_evt`, where an external interrupt controller can mask it. Writing one to the clear bit of the command register zeroes the count, drops the flag and restarts both dividers. The run bit in the same register starts and stops counting.

Top module: `aont_match_timer`

## Requirements
- R1: After reset, every register reads 0 and `match_evt` is low.
- R2: Control bit 25 = 1 selects the bus clock as the source, with a tick every cycle. With bit 25 = 0, control bit 0 picks the source: 0 selects `osc0_tick` and 1 selects `osc1_tick`. An unselected source has no effect on the count.
- R3: Control bit 24 enables the first divider. Its field in control bits 23:20 holding N gives one output tick per N+1 source ticks. With bit 24 = 0 every source tick passes through.
- R4: The divider register at offset 0x74 holding D gives one count step per D first-stage ticks, and D = 0 behaves as D = 1. The count changes by at most one per cycle.
- R5: Command register (0x6C) bit 0 is the run bit. While it is 0 the count holds its value, and setting it again resumes counting from that value.
- R6: Writing a command word with bit 1 = 1 zeroes the count, clears the match flag and restarts both dividers, all at the next edge. Bit 1 always reads back 0, and a command write with bit 1 = 0 leaves the flag unchanged.
- R7: The increment that makes the count equal the end register (0x70) sets bit 0 of the status register (0x7C) and bit 0 of the auxiliary register (0x04) together. After that the count no longer advances, and the flag stays set until a clear command.
- R8: `match_evt` goes high at the clock edge that sets the match flag and stays high while the flag is set.
- R9: If a clear command arrives in the same cycle as the increment that would match, the clear wins: count 0 and flag 0.
- R10: The count (0x78), status (0x7C) and auxiliary (0x04) registers ignore writes, and reading any register changes no state.
- R11: A read strobe returns the addressed register's value on `bus_rdata` one cycle later. The control register reads back bits 25, 24, 23:20 and 0 as written, and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the bus-clock tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| osc0_tick | input | 1 | Tick enable from oscillator 0 |
| osc1_tick | input | 1 | Tick enable from oscillator 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| match_evt | output | 1 | Match event level toward the interrupt controller |

## Verification
Two functions can fall on the same edge: the clear command and the count increment that reaches the end value. The bench sets the source to the bus clock, the divider to one and the end value to 5. It starts the timer with a combined clear-and-run write, then times a clear write so that it is sampled at exactly the fifth counting edge. It then expects the count at 0, both flag copies at 0 and `match_evt` low, whereas an uncolliding run to the same edge leaves the count at 5 with the flag set.

// File: rtl/aont_pkg.sv
// Package: shared offsets, bit positions and the source configuration type
// for the always-on compare timer. Assumes byte offsets fit in 8 bits.
package aont_pkg;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_AUX  = 'h04;
    localparam int OFS_CMD  = 'h6C;
    localparam int OFS_END  = 'h70;
    localparam int OFS_DIV  = 'h74;
    localparam int OFS_CNT  = 'h78;
    localparam int OFS_STAT = 'h7C;

    localparam int CTRL_OSC_BIT  = 0;
    localparam int CTRL_FDIV_LO  = 20;
    localparam int FDIV_W        = 4;
    localparam int CTRL_FEN_BIT  = 24;
    localparam int CTRL_PSEL_BIT = 25;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_CLR_BIT = 1;

    typedef struct packed {
        logic              pclk_sel;
        logic              fdiv_en;
        logic [FDIV_W-1:0] fdiv_val;
        logic              osc_sel;
    } src_cfg_t;
endpackage

// File: rtl/aont_regs.sv
// Module: register file and bus decode. Writes land at the next edge; reads
// are registered and appear one cycle after the strobe. Command clear is a
// combinational pulse during the write cycle. Assumes DW >= 26.
module aont_regs
    import aont_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cnt,
    input  logic          flag,
    output logic [DW-1:0] bus_rdata,
    output src_cfg_t      cfg,
    output logic          run,
    output logic          clr_cmd,
    output logic          restart,
    output logic [DW-1:0] end_val,
    output logic [DW-1:0] div_val
);
    logic hit_ctrl, hit_aux, hit_cmd, hit_end, hit_div, hit_cnt, hit_stat;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] ctrl_view;

    // Address decode for every register.
    always_comb begin
        hit_ctrl = (bus_addr == AW'(OFS_CTRL));
        hit_aux  = (bus_addr == AW'(OFS_AUX));
        hit_cmd  = (bus_addr == AW'(OFS_CMD));
        hit_end  = (bus_addr == AW'(OFS_END));
        hit_div  = (bus_addr == AW'(OFS_DIV));
        hit_cnt  = (bus_addr == AW'(OFS_CNT));
        hit_stat = (bus_addr == AW'(OFS_STAT));
    end

    // Strobes: clear command and divider restart for the datapath.
    always_comb begin
        clr_cmd = bus_wr && hit_cmd && bus_wdata[CMD_CLR_BIT];
        restart = bus_wr && (hit_ctrl || hit_div || (hit_cmd && bus_wdata[CMD_CLR_BIT]));
    end

    // Writable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            run     <= 1'b0;
            end_val <= '0;
            div_val <= '0;
        end else if (bus_wr) begin
            if (hit_ctrl) begin
                cfg.pclk_sel <= bus_wdata[CTRL_PSEL_BIT];
                cfg.fdiv_en  <= bus_wdata[CTRL_FEN_BIT];
                cfg.fdiv_val <= bus_wdata[CTRL_FDIV_LO +: FDIV_W];
                cfg.osc_sel  <= bus_wdata[CTRL_OSC_BIT];
            end
            if (hit_cmd) run     <= bus_wdata[CMD_RUN_BIT];
            if (hit_end) end_val <= bus_wdata;
            if (hit_div) div_val <= bus_wdata;
        end
    end

    // Rebuild the control word from its fields.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_PSEL_BIT]             = cfg.pclk_sel;
        ctrl_view[CTRL_FEN_BIT]              = cfg.fdiv_en;
        ctrl_view[CTRL_FDIV_LO +: FDIV_W]    = cfg.fdiv_val;
        ctrl_view[CTRL_OSC_BIT]              = cfg.osc_sel;
    end

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)              rd_mux = ctrl_view;
        if (hit_aux || hit_stat)   rd_mux = {{(DW-1){1'b0}}, flag};
        if (hit_cmd)               rd_mux[CMD_RUN_BIT] = run;
        if (hit_end)               rd_mux = end_val;
        if (hit_div)               rd_mux = div_val;
        if (hit_cnt)               rd_mux = cnt;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/aont_prescale.sv
// Module: source selection and first divider. Produces a one-cycle tick
// enable; no clock is gated or muxed. Assumes oscillator ticks are already
// single-cycle pulses in this clock domain.
module aont_prescale
    import aont_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     osc0_tick,
    input  logic     osc1_tick,
    input  src_cfg_t cfg,
    input  logic     restart,
    output logic     sclk_tick
);
    logic              src_tick;
    logic [FDIV_W-1:0] fcnt;
    logic              fwrap;

    // Pick the active source tick.
    always_comb begin
        if (cfg.pclk_sel)     src_tick = 1'b1;
        else if (cfg.osc_sel) src_tick = osc1_tick;
        else                  src_tick = osc0_tick;
    end

    // Divider wraps when the count reaches the programmed field.
    always_comb begin
        fwrap     = (fcnt >= cfg.fdiv_val);
        sclk_tick = src_tick && (!cfg.fdiv_en || fwrap);
    end

    // First divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)              fcnt <= '0;
        else if (cfg.fdiv_en && src_tick)   fcnt <= fwrap ? '0 : fcnt + 1'b1;
    end
endmodule

// File: rtl/aont_rate_div.sv
// Module: second divider setting the count rate. A value of zero behaves as
// one. Advances only while enabled so that a restart gives a known phase.
module aont_rate_div #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_tick,
    input  logic          enable,
    input  logic          restart,
    input  logic [DW-1:0] div_val,
    output logic          rate_tick
);
    logic [DW-1:0] rcnt;
    logic [DW-1:0] last;
    logic          wrap;

    // Terminal count, with zero folded onto divide-by-one.
    always_comb begin
        last      = (div_val == '0) ? '0 : div_val - 1'b1;
        wrap      = (rcnt >= last);
        rate_tick = enable && sclk_tick && wrap;
    end

    // Rate divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)        rcnt <= '0;
        else if (enable && sclk_tick) rcnt <= wrap ? '0 : rcnt + 1'b1;
    end
endmodule

// File: rtl/aont_counter.sv
// Module: main up-counter with end compare and sticky match flag. Clear has
// priority over an increment in the same cycle. The counter freezes after a
// match until cleared.
module aont_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          rate_tick,
    input  logic [DW-1:0] end_val,
    output logic [DW-1:0] cnt,
    output logic          flag
);
    logic [DW-1:0] nxt;
    logic          step;

    // Next value and step condition.
    always_comb begin
        nxt  = cnt + 1'b1;
        step = run && rate_tick && !flag;
    end

    // Count and flag state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (step) begin
            cnt <= nxt;
            if (nxt == end_val) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/aont_match_timer.sv
// Module: top of the always-on compare timer. Connects register file,
// prescaler, rate divider and counter. Assumes one clock domain; all
// sources arrive as tick enables.
module aont_match_timer #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          osc0_tick,
    input  logic          osc1_tick,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          match_evt
);
    aont_pkg::src_cfg_t cfg;
    logic          run_q, clr_cmd, restart, sclk_tick, rate_tick, flag_q;
    logic [DW-1:0] end_q, div_q, cnt_q;

    aont_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q), .flag(flag_q),
        .bus_rdata(bus_rdata), .cfg(cfg), .run(run_q), .clr_cmd(clr_cmd),
        .restart(restart), .end_val(end_q), .div_val(div_q)
    );

    aont_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .osc0_tick(osc0_tick), .osc1_tick(osc1_tick),
        .cfg(cfg), .restart(restart), .sclk_tick(sclk_tick)
    );

    aont_rate_div #(.DW(DW)) u_rate (
        .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .enable(run_q && !flag_q),
        .restart(restart), .div_val(div_q), .rate_tick(rate_tick)
    );

    aont_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_cmd), .run(run_q), .rate_tick(rate_tick),
        .end_val(end_q), .cnt(cnt_q), .flag(flag_q)
    );

    // Match event level toward the interrupt controller.
    assign match_evt = flag_q;
endmodule

// File: rtl/aont_checker.sv
// Module: assertion checker for the compare timer, bound into the top.
module aont_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          run,
    input logic          rate_tick,
    input logic          flag,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] end_val
);
    p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !flag);

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && run && rate_tick && !flag) |=> !flag);

    p_sticky_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag && $stable(cnt));

    p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && run && rate_tick && !flag && (DW'(cnt + 1'b1) == end_val)) |=> flag);

    p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == end_val));

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == DW'($past(cnt) + 1'b1)));
endmodule

bind aont_match_timer aont_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr_cmd), .run(run_q), .rate_tick(rate_tick),
    .flag(flag_q), .cnt(cnt_q), .end_val(end_q)
);

// File: tb/aont_match_timer_tb.sv
module aont_match_timer_tb;
    localparam logic [7:0] A_CTRL = 8'h00, A_AUX = 8'h04, A_CMD = 8'h6C,
                           A_END = 8'h70, A_DIV = 8'h74, A_CNT = 8'h78, A_STAT = 8'h7C;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        osc0_tick = 1'b1, osc1_tick = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        match_evt;
    logic        rd_pend = 1'b0;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;
    rd_item_t    exp_q[$];

    aont_match_timer u_dut (
        .clk(clk), .rst_n(rst_n), .osc0_tick(osc0_tick), .osc1_tick(osc1_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .match_evt(match_evt)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: queue the expected value, then issue the read.
    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: a read sampled at an edge is compared at the next low phase.
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) check(bus_rdata, 32'hDEAD_BEEF, "scoreboard underflow");
            else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({31'd0, match_evt}, 0, "R1 evt after reset");
        rd_expect(A_CNT, 0, "R1 count");
        rd_expect(A_STAT, 0, "R1 status");
        rd_expect(A_AUX, 0, "R1 aux");
        rd_expect(A_CMD, 0, "R1 cmd");
        rd_expect(A_CTRL, 0, "R1 ctrl");
        // R10 read-only registers ignore writes
        wr(A_CNT, 32'h1234); wr(A_STAT, 1); wr(A_AUX, 1);
        rd_expect(A_CNT, 0, "R10 count write ignored");
        rd_expect(A_STAT, 0, "R10 status write ignored");
        rd_expect(A_AUX, 0, "R10 aux write ignored");
        // R2/R7/R8: bus clock source, divide 1, end 5
        wr(A_CTRL, 32'h0200_0000); wr(A_END, 5); wr(A_DIV, 0);
        rd_expect(A_CTRL, 32'h0200_0000, "R11 ctrl readback");
        wr(A_CMD, 3);
        repeat (4) @(negedge clk);
        check({31'd0, match_evt}, 0, "R8 evt before match");
        @(negedge clk);
        check({31'd0, match_evt}, 1, "R8 evt at match");
        rd_expect(A_CNT, 5, "R7 count at end");
        rd_expect(A_STAT, 1, "R7 status set");
        rd_expect(A_AUX, 1, "R7 aux mirror");
        repeat (4) @(negedge clk);
        rd_expect(A_CNT, 5, "R7 frozen after match");
        rd_expect(A_CNT, 5, "R10 read no side effect");
        // R6 clear semantics
        wr(A_CMD, 1);
        rd_expect(A_STAT, 1, "R6 write without clear keeps flag");
        wr(A_CMD, 2);
        rd_expect(A_CNT, 0, "R6 count cleared");
        rd_expect(A_STAT, 0, "R6 status cleared");
        rd_expect(A_AUX, 0, "R6 aux cleared");
        rd_expect(A_CMD, 0, "R6 clear bit reads 0");
        check({31'd0, match_evt}, 0, "R6 evt cleared");
        // R5 stop holds, resume continues
        wr(A_END, 1000);
        wr(A_CMD, 3);
        repeat (4) @(negedge clk);
        wr(A_CMD, 0);
        rd_expect(A_CNT, 6, "R5 count at stop");
        repeat (5) @(negedge clk);
        rd_expect(A_CNT, 6, "R5 count holds");
        wr(A_CMD, 1); wr(A_CMD, 0);
        rd_expect(A_CNT, 8, "R5 resume from held value");
        // R9 clear collides with matching increment
        wr(A_END, 5);
        wr(A_CMD, 3);
        repeat (3) @(negedge clk);
        wr(A_CMD, 2);
        check({31'd0, match_evt}, 0, "R9 evt after collision");
        rd_expect(A_CNT, 0, "R9 count after collision");
        rd_expect(A_STAT, 0, "R9 status after collision");
        // R4 rate divider of 3
        wr(A_DIV, 3); wr(A_END, 4);
        wr(A_CMD, 3);
        repeat (11) @(negedge clk);
        check({31'd0, match_evt}, 0, "R4 evt before 12th edge");
        @(negedge clk);
        check({31'd0, match_evt}, 1, "R4 evt at 12th edge");
        rd_expect(A_CNT, 4, "R4 count at end");
        wr(A_CMD, 2);
        // R3 first divider N=1 (divide by 2)
        wr(A_CTRL, 32'h0310_0000); wr(A_DIV, 1); wr(A_END, 3);
        rd_expect(A_CTRL, 32'h0310_0000, "R11 ctrl fields readback");
        wr(A_CMD, 3);
        repeat (5) @(negedge clk);
        check({31'd0, match_evt}, 0, "R3 evt before 6th edge");
        @(negedge clk);
        check({31'd0, match_evt}, 1, "R3 evt at 6th edge");
        wr(A_CMD, 2);
        // R2 oscillator selection
        wr(A_CTRL, 32'h0000_0001); wr(A_DIV, 0); wr(A_END, 5);
        wr(A_CMD, 3);
        repeat (10) @(negedge clk);
        rd_expect(A_CNT, 0, "R2 idle oscillator 1 gives no ticks");
        wr(A_CTRL, 32'h0000_0000);
        repeat (10) @(negedge clk);
        rd_expect(A_CNT, 5, "R2 oscillator 0 ticks counted");
        rd_expect(A_STAT, 1, "R2 match via oscillator 0");
        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "scoreboard drained");
        finish_run();
    end
endmodule